// File: doc/BRIEF.md
# Bidirectional Linear Ramp Generator

This block produces a 32-bit digital ramp that drives one control parameter of a synthesizer core: the output frequency word, the phase offset or the amplitude scale. The ramp moves between a programmed floor and ceiling. Each direction has its own step size and its own step interval, so the rising and falling slopes can differ.

A live direction input selects rising or falling on every clock. A hold input freezes both the ramp and its step timer, even partway through a sweep. Software programs the six slope and limit registers through a simple parallel write port. The block presents the raw ramp word, a copy reformatted for the chosen destination, and a flag that is high while the ramp sits at the limit it is heading for.

Top module: `lin_ramp_gen`

## Requirements
- R1: A synchronous active-high `rst` clears all six registers, the ramp word, the formatted word and the flag to zero. The ramp therefore starts at the (zero) floor.
- R2: A write (`wr_en` high at a clock edge) stores `wr_data` into one register chosen by `wr_addr`: 0 floor, 1 ceiling, 2 rising step, 3 falling step, 4 rising interval, 5 falling interval. An interval register keeps the low 16 bits.
- R3: When `dir_up` is high, each step event adds the rising step to the ramp.
- R4: A step never passes a limit. A rising step that would reach or pass the ceiling, or carry out of 32 bits, leaves the ramp at the ceiling. A falling step that would reach or go below the floor, or borrow, leaves the ramp at the floor.
- R5: An interval register holding N produces one step event every N+1 clock cycles. After each step event the timer reloads from the interval of the direction in force at that event.
- R6: `sweep_done` is high, with the same latency as the ramp word, exactly when the ramp equals the limit targeted by the current direction (the ceiling when rising, the floor when falling). It therefore drops once the direction is reversed.
- R7: While `hold` is high, the ramp word and the step timer keep their values.
- R8: `param_word` follows the ramp with the same latency, formatted by `dest_sel`: 0 gives all 32 bits, 1 gives the top 16 bits right-aligned, 2 gives the top 14 bits right-aligned, 3 gives zero. All unused upper bits are zero.
- R9: When `dir_up` is low, each step event subtracts the falling step from the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write value |
| dir_up | input | 1 | High: rise toward ceiling; low: fall toward floor |
| hold | input | 1 | Freeze ramp and step timer |
| dest_sel | input | 2 | Destination format select |
| ramp_word | output | 32 | Raw ramp value |
| param_word | output | 32 | Destination-formatted ramp value |
| sweep_done | output | 1 | Ramp sits at the targeted limit |

## Verification
The hardest case to reach is a clamp that comes from 32-bit carry or borrow rather than from an ordinary comparison. The stimulus first places the ramp far below the floor while falling, which produces a borrow that clamps the ramp up to the floor. It then parks the ramp near the top of the range and applies a half-range rising step, which carries out of 32 bits. Step spacing is measured as the gap between successive value changes, so the check does not depend on the timer phase when the direction flips.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic [1:0] {
    DST_FREQ  = 2'd0,
    DST_PHASE = 2'd1,
    DST_AMPL  = 2'd2,
    DST_NONE  = 2'd3
  } dest_e;

  typedef enum logic [2:0] {
    RA_FLOOR = 3'd0,
    RA_CEIL  = 3'd1,
    RA_RSTEP = 3'd2,
    RA_FSTEP = 3'd3,
    RA_RIVL  = 3'd4,
    RA_FIVL  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/ramp_regs.sv
module ramp_regs #(
  parameter int W  = 32,
  parameter int IW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  lim_lo,
  output logic [W-1:0]  lim_hi,
  output logic [W-1:0]  step_up,
  output logic [W-1:0]  step_dn,
  output logic [IW-1:0] ivl_up,
  output logic [IW-1:0] ivl_dn
);
  import ramp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_lo  <= '0;
      lim_hi  <= '0;
      step_up <= '0;
      step_dn <= '0;
      ivl_up  <= '0;
      ivl_dn  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_FLOOR: lim_lo  <= wr_data;
        RA_CEIL:  lim_hi  <= wr_data;
        RA_RSTEP: step_up <= wr_data;
        RA_FSTEP: step_dn <= wr_data;
        RA_RIVL:  ivl_up  <= wr_data[IW-1:0];
        RA_FIVL:  ivl_dn  <= wr_data[IW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ramp_pacer.sv
module ramp_pacer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          dir_up,
  input  logic [IW-1:0] ivl_up,
  input  logic [IW-1:0] ivl_dn,
  output logic          tick
);
  logic [IW-1:0] cnt_q;

  assign tick = (cnt_q == '0) && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!hold) begin
      if (cnt_q == '0) cnt_q <= dir_up ? ivl_up : ivl_dn;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ramp_core.sv
module ramp_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         dir_up,
  input  logic [W-1:0] lim_lo,
  input  logic [W-1:0] lim_hi,
  input  logic [W-1:0] step_up,
  input  logic [W-1:0] step_dn,
  output logic [W-1:0] ramp_q,
  output logic [W-1:0] ramp_d,
  output logic         done_q
);
  logic [W:0]   sum_w;
  logic [W:0]   dif_w;
  logic [W-1:0] up_nx;
  logic [W-1:0] dn_nx;
  logic         done_d;

  always_comb begin
    sum_w  = {1'b0, ramp_q} + {1'b0, step_up};
    dif_w  = {1'b0, ramp_q} - {1'b0, step_dn};
    up_nx  = (sum_w[W] || sum_w[W-1:0] >= lim_hi) ? lim_hi : sum_w[W-1:0];
    dn_nx  = (dif_w[W] || dif_w[W-1:0] <= lim_lo) ? lim_lo : dif_w[W-1:0];
    ramp_d = tick ? (dir_up ? up_nx : dn_nx) : ramp_q;
    done_d = dir_up ? (ramp_d == lim_hi) : (ramp_d == lim_lo);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q <= '0;
      done_q <= 1'b0;
    end else begin
      ramp_q <= ramp_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/ramp_fmt.sv
module ramp_fmt #(
  parameter int W  = 32,
  parameter int PW = 16,
  parameter int MW = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   dest_sel,
  input  logic [W-1:0] ramp_d,
  output logic [W-1:0] param_q
);
  import ramp_pkg::*;

  logic [W-1:0] fmt_w;

  always_comb begin
    case (dest_e'(dest_sel))
      DST_FREQ:  fmt_w = ramp_d;
      DST_PHASE: fmt_w = {{(W-PW){1'b0}}, ramp_d[W-1 -: PW]};
      DST_AMPL:  fmt_w = {{(W-MW){1'b0}}, ramp_d[W-1 -: MW]};
      default:   fmt_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) param_q <= '0;
    else     param_q <= fmt_w;
  end
endmodule

// File: rtl/lin_ramp_gen.sv
module lin_ramp_gen #(
  parameter int W  = 32,
  parameter int IW = 16,
  parameter int PW = 16,
  parameter int MW = 14,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          dir_up,
  input  logic          hold,
  input  logic [1:0]    dest_sel,
  output logic [W-1:0]  ramp_word,
  output logic [W-1:0]  param_word,
  output logic          sweep_done
);
  logic [W-1:0]  lim_lo, lim_hi, step_up, step_dn, ramp_d;
  logic [IW-1:0] ivl_up, ivl_dn;
  logic          tick;

  ramp_regs #(.W(W), .IW(IW), .AW(AW)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .step_up(step_up), .step_dn(step_dn),
    .ivl_up(ivl_up), .ivl_dn(ivl_dn)
  );

  ramp_pacer #(.IW(IW)) i_pacer (
    .clk(clk), .rst(rst), .hold(hold), .dir_up(dir_up),
    .ivl_up(ivl_up), .ivl_dn(ivl_dn), .tick(tick)
  );

  ramp_core #(.W(W)) i_core (
    .clk(clk), .rst(rst), .tick(tick), .dir_up(dir_up),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .step_up(step_up), .step_dn(step_dn),
    .ramp_q(ramp_word), .ramp_d(ramp_d), .done_q(sweep_done)
  );

  ramp_fmt #(.W(W), .PW(PW), .MW(MW)) i_fmt (
    .clk(clk), .rst(rst), .dest_sel(dest_sel), .ramp_d(ramp_d),
    .param_q(param_word)
  );
endmodule

// File: rtl/ramp_chk.sv
module ramp_chk #(
  parameter int W  = 32,
  parameter int MW = 14
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         hold,
  input logic         dir_up,
  input logic [1:0]   dest_sel,
  input logic [W-1:0] ramp_word,
  input logic [W-1:0] param_word,
  input logic         sweep_done,
  input logic [W-1:0] lim_lo,
  input logic [W-1:0] lim_hi
);
  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(ramp_word));

  p_rise_no_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (dir_up && !hold && ramp_word <= lim_hi) |=> ramp_word >= $past(ramp_word));

  p_fall_no_climb_r9: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && !hold && ramp_word >= lim_lo) |=> ramp_word <= $past(ramp_word));

  p_flag_at_limit_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(sweep_done) && !$past(wr_en)) |-> (ramp_word == lim_hi || ramp_word == lim_lo));

  p_freq_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(dest_sel) == 2'd0) |-> (param_word == ramp_word));

  p_ampl_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(dest_sel) == 2'd2) |-> (param_word[W-1:MW] == '0));
endmodule

bind lin_ramp_gen ramp_chk #(.W(W), .MW(MW)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .hold(hold), .dir_up(dir_up),
  .dest_sel(dest_sel), .ramp_word(ramp_word), .param_word(param_word),
  .sweep_done(sweep_done), .lim_lo(lim_lo), .lim_hi(lim_hi)
);

// File: tb/test_lin_ramp_gen.sv
module test_lin_ramp_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        dir_up = 1'b0;
  logic        hold = 1'b0;
  logic [1:0]  dest_sel = '0;
  logic [31:0] ramp_word, param_word;
  logic        sweep_done;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  lin_ramp_gen i_lin_ramp_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dir_up(dir_up), .hold(hold), .dest_sel(dest_sel),
    .ramp_word(ramp_word), .param_word(param_word), .sweep_done(sweep_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic step_wait(input logic [31:0] prev, output logic [31:0] val, output int gap);
    gap = 0;
    val = prev;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      gap++;
      if (ramp_word != prev) begin
        val = ramp_word;
        return;
      end
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idle(3);
    chk("R1 ramp", ramp_word, 32'h0);
    chk("R1 param", param_word, 32'h0);
    chk("R1 flag", {31'b0, sweep_done}, 32'h0);
    rst = 1'b0;
    idle(2);
    chk("R6 flag at zero floor", {31'b0, sweep_done}, 32'h1);
  endtask

  task automatic t_rise_hold;
    logic [31:0] v;
    int g;
    wr(3'd0, 32'd100);
    wr(3'd1, 32'd1000);
    wr(3'd2, 32'd350);
    wr(3'd4, 32'd3);
    wr(3'd3, 32'd400);
    wr(3'd5, 32'd1);
    idle(4);
    chk("R4 borrow clamps to floor", ramp_word, 32'd100);
    dir_up = 1'b1;
    step_wait(32'd100, v, g);
    chk("R3 first rise", v, 32'd450);
    chk("R6 flag low mid sweep", {31'b0, sweep_done}, 32'h0);
    step_wait(v, v, g);
    chk("R3 second rise", v, 32'd800);
    chk("R5 rise gap", g, 32'd4);
    hold = 1'b1;
    idle(10);
    chk("R7 hold keeps value", ramp_word, 32'd800);
    hold = 1'b0;
    step_wait(32'd800, v, g);
    chk("R4 clamp at ceiling", v, 32'd1000);
    chk("R6 flag at ceiling", {31'b0, sweep_done}, 32'h1);
    idle(8);
    chk("R4 stays at ceiling", ramp_word, 32'd1000);
  endtask

  task automatic t_fall;
    logic [31:0] v;
    int g;
    dir_up = 1'b0;
    @(negedge clk);
    chk("R6 flag drops on reversal", {31'b0, sweep_done}, 32'h0);
    step_wait(32'd1000, v, g);
    chk("R9 first fall", v, 32'd600);
    step_wait(v, v, g);
    chk("R9 second fall", v, 32'd200);
    chk("R5 fall gap", g, 32'd2);
    step_wait(v, v, g);
    chk("R4 clamp at floor", v, 32'd100);
    chk("R6 flag at floor", {31'b0, sweep_done}, 32'h1);
  endtask

  task automatic t_carry;
    logic [31:0] v;
    int g;
    wr(3'd0, 32'hF000_0000);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h8000_0000);
    wr(3'd4, 32'd0);
    idle(4);
    chk("R2 floor write moves ramp", ramp_word, 32'hF000_0000);
    dir_up = 1'b1;
    step_wait(32'hF000_0000, v, g);
    chk("R4 carry clamps to ceiling", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_dest;
    wr(3'd0, 32'hDEAD_BEEF);
    wr(3'd3, 32'h8000_0000);
    dir_up = 1'b0;
    idle(6);
    chk("R9 fall to new floor", ramp_word, 32'hDEAD_BEEF);
    dest_sel = 2'd0; idle(2);
    chk("R8 frequency", param_word, 32'hDEAD_BEEF);
    dest_sel = 2'd1; idle(2);
    chk("R8 phase", param_word, 32'h0000_DEAD);
    dest_sel = 2'd2; idle(2);
    chk("R8 amplitude", param_word, 32'h0000_37AB);
    dest_sel = 2'd3; idle(2);
    chk("R8 no destination", param_word, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rise_hold();
    t_fall();
    t_carry();
    t_dest();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule